// File: doc/BRIEF.md
# Binary Morphology Window Unit

This block computes one output pixel of a binary erosion or dilation from a square neighbourhood of a one-bit image. The neighbourhood arrives as a flattened WIN×WIN bit vector. The structuring element sits in a programmable weight register of the same shape. A weight bit of 0 removes its cell from the decision. A weight bit of 1 makes the cell count. A one-bit operation select picks erosion or dilation for each window, and both operations share one cell array and one reduction tree.

A feeder walks an image and presents one window per accepted transfer. Neighbourhood positions that fall outside the image must be presented as 0 bits. Closing and opening are built by running a whole frame through the unit twice with the same weights: dilation then erosion gives closing, and erosion then dilation gives opening.

Both the window stream and the result stream use valid/ready. A window is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its result is being taken in the same cycle. A result that is not accepted holds its value until `out_ready` rises. The weight load is a plain strobe and is not handshaked.

Top module: `morph_window`

## Requirements
- R1: In erosion (`op_sel`=0), `out_pix` is 1 exactly when every cell whose weight bit is 1 has pixel bit 1. Cell (row r, column c) is bit r*WIN+c of both `in_win` and `wgt_data`.
- R2: In dilation (`op_sel`=1), `out_pix` is 1 exactly when at least one cell has both its weight bit and its pixel bit at 1.
- R3: With an all-zero weight mask, erosion yields 1 and dilation yields 0 for any window.
- R4: With an all-ones mask, erosion yields the AND of all window bits and dilation yields their OR.
- R5: The weight register changes only on an edge where `wgt_load` is 1. A window accepted on that same edge still uses the previous mask, and windows accepted on later edges use the new one.
- R6: A window accepted on an edge produces its result, with `out_valid` high, right after that edge. The operation select is sampled together with the window.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_pix` keeps its value and `in_ready` is 0, so no window is taken.
- R8: After reset, `out_valid` is 0, `in_ready` is 1, and the mask is all ones (solid element).
- R9: Running every zero-padded window of a frame through dilation, then the result through erosion with the same mask, gives the closing of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wgt_load | input | 1 | Strobe that captures `wgt_data` into the weight register |
| wgt_data | input | WIN*WIN | New structuring element, bit r*WIN+c is cell (r,c) |
| op_sel | input | 1 | 0 selects erosion, 1 selects dilation |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Unit can take a window |
| in_win | input | WIN*WIN | Flattened neighbourhood, bit r*WIN+c is cell (r,c) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pix | output | 1 | Eroded or dilated pixel |

## Verification
On every cycle, the assertions check the handshake: a stalled result holds its value, an accepted window always yields a result, and the mask moves only on a load strobe. They also check the all-zero and all-ones mask outcomes against the window that was taken. The per-cell erosion and dilation rules under arbitrary masks can only be shown by the bench's scenarios. The same holds for the exact edge on which a new mask takes effect and for whole-frame closing over zero-padded borders, which compare results against values computed from the requirements.

// File: rtl/morph_pkg.sv
package morph_pkg;
  typedef enum logic {
    MORPH_ERODE  = 1'b0,
    MORPH_DILATE = 1'b1
  } morph_op_e;
endpackage

// File: rtl/morph_cell_array.sv
// Per-cell gating. Each cell emits a term that is 1 when it does not veto the
// shared AND tree: erosion vetoes on (weight=1, pixel=0), dilation vetoes on
// (weight=1, pixel=1) and the top inverts the tree result for dilation.
module morph_cell_array
  import morph_pkg::*;
#(
  parameter int CELLS = 9
) (
  input  logic [CELLS-1:0] pix,
  input  logic [CELLS-1:0] wgt,
  input  morph_op_e        op,
  output logic [CELLS-1:0] pass
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    always_comb begin
      if (op == MORPH_DILATE) pass[i] = ~(wgt[i] & pix[i]);
      else                    pass[i] = ~wgt[i] | pix[i];
    end
  end
endmodule

// File: rtl/morph_and_tree.sv
// Balanced AND reduction laid out as a heap: leaves at P..P+WIDTH-1,
// padding leaves tied to 1, node k combines nodes 2k and 2k+1.
module morph_and_tree #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] leaf,
  output logic             all_set
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int P      = 1 << LEVELS;

  logic [2*P-1:1] node;

  always_comb begin
    node = '1;
    for (int i = 0; i < WIDTH; i++) node[P+i] = leaf[i];
    for (int k = P - 1; k >= 1; k--) node[k] = node[2*k] & node[2*k+1];
  end

  assign all_set = node[1];
endmodule

// File: rtl/morph_window.sv
module morph_window
  import morph_pkg::*;
#(
  parameter int WIN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wgt_load,
  input  logic [WIN*WIN-1:0]   wgt_data,
  input  logic                 op_sel,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WIN*WIN-1:0]   in_win,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_pix
);
  localparam int CELLS = WIN * WIN;

  morph_op_e        op;
  logic [CELLS-1:0] wmask;
  logic [CELLS-1:0] pass;
  logic             tree_all;
  logic             fire;

  assign op       = morph_op_e'(op_sel);
  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  // Structuring element register, solid after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wmask <= '1;
    else if (wgt_load) wmask <= wgt_data;
  end

  morph_cell_array #(.CELLS(CELLS)) u_cells (
    .pix  (in_win),
    .wgt  (wmask),
    .op   (op),
    .pass (pass)
  );

  morph_and_tree #(.WIDTH(CELLS)) u_tree (
    .leaf    (pass),
    .all_set (tree_all)
  );

  // Single output register with valid/ready.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_pix   <= (op == MORPH_DILATE) ? ~tree_all : tree_all;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r5_mask_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !wgt_load |=> $stable(wmask));

  a_r6_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r7_no_take_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_empty_mask_erode: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wmask == '0 && !op_sel) |=> out_pix);

  a_r3_empty_mask_dilate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wmask == '0 && op_sel) |=> !out_pix);

  a_r4_solid_erode: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wmask == '1 && !op_sel) |=> (out_pix == $past(&in_win)));

  a_r4_solid_dilate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wmask == '1 && op_sel) |=> (out_pix == $past(|in_win)));
endmodule

// File: tb/morph_window_bench.sv
`timescale 1ns/1ps
module morph_window_bench;
  localparam int N = 3;
  localparam int C = N * N;
  localparam int IMG = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wgt_load = 1'b0;
  logic [C-1:0] wgt_data = '0;
  logic op_sel = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [C-1:0] in_win = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_pix;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  morph_window #(.WIN(N)) u_morph_window (
    .clk(clk), .rst_n(rst_n), .wgt_load(wgt_load), .wgt_data(wgt_data),
    .op_sel(op_sel), .in_valid(in_valid), .in_ready(in_ready), .in_win(in_win),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  // {op, mask, window, expected}
  localparam logic [19:0] VEC [13] = '{
    {1'b0, 9'h1FF, 9'h1FF, 1'b1},  // R4 solid erode full
    {1'b0, 9'h1FF, 9'h1EF, 1'b0},  // R4 solid erode hole
    {1'b1, 9'h1FF, 9'h000, 1'b0},  // R4 solid dilate empty
    {1'b1, 9'h1FF, 9'h001, 1'b1},  // R4 solid dilate corner
    {1'b0, 9'h000, 9'h000, 1'b1},  // R3 empty mask erode
    {1'b1, 9'h000, 9'h1FF, 1'b0},  // R3 empty mask dilate
    {1'b0, 9'h0BA, 9'h0BA, 1'b1},  // R1 plus fits
    {1'b0, 9'h0BA, 9'h1F7, 1'b0},  // R1 plus arm missing
    {1'b0, 9'h0BA, 9'h145, 1'b0},  // R1 only don't-care cells set
    {1'b1, 9'h0BA, 9'h145, 1'b0},  // R2 no overlap
    {1'b1, 9'h0BA, 9'h110, 1'b1},  // R2 centre overlap
    {1'b1, 9'h010, 9'h1EF, 1'b0},  // R2 centre-only mask, centre clear
    {1'b0, 9'h010, 9'h010, 1'b1}   // R1 centre-only mask, centre set
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic model(input logic m, input logic [C-1:0] w, input logic [C-1:0] p);
    return m ? |(w & p) : &(~w | p);
  endfunction

  task automatic load_mask(input logic [C-1:0] w);
    @(negedge clk);
    wgt_load = 1'b1; wgt_data = w;
    @(negedge clk);
    wgt_load = 1'b0;
  endtask

  task automatic run_win(input logic m, input logic [C-1:0] p, output logic v, output logic got);
    @(negedge clk);
    in_valid = 1'b1; op_sel = m; in_win = p; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    v = out_valid; got = out_pix;
  endtask

  function automatic logic [C-1:0] window_at(input logic [IMG*IMG-1:0] im, input int y, input int x);
    logic [C-1:0] w = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int yy = y + r - (N - 1) / 2;
        int xx = x + c - (N - 1) / 2;
        if (yy >= 0 && yy < IMG && xx >= 0 && xx < IMG) w[r*N+c] = im[yy*IMG+xx];
      end
    return w;
  endfunction

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic v, got;
    logic [C-1:0] m;
    logic [IMG*IMG-1:0] img, mid, fin, emid, efin;

    // R8 reset state
    #1;
    check("R8 out_valid in reset", out_valid, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 out_valid after reset", out_valid, 1'b0);
    check("R8 in_ready after reset", in_ready, 1'b1);
    run_win(1'b0, 9'h1EF, v, got);
    check("R8 solid default erode", got, 1'b0);
    run_win(1'b1, 9'h001, v, got);
    check("R8 solid default dilate", got, 1'b1);

    // Table walk
    for (int i = 0; i < 13; i++) begin
      load_mask(VEC[i][18:10]);
      run_win(VEC[i][19], VEC[i][9:1], v, got);
      check("R6 valid on table vector", v, 1'b1);
      check("R1 R2 R3 R4 table vector", got, VEC[i][0]);
    end

    // R5: window taken on the load edge uses the previous mask
    load_mask(9'h1FF);
    @(negedge clk);
    wgt_load = 1'b1; wgt_data = 9'h000;
    in_valid = 1'b1; op_sel = 1'b0; in_win = 9'h000;
    @(negedge clk);
    wgt_load = 1'b0; in_valid = 1'b0;
    check("R5 same-edge window uses old mask", out_pix, 1'b0);
    run_win(1'b0, 9'h000, v, got);
    check("R5 next window uses new mask", got, 1'b1);

    // R7 back-pressure
    load_mask(9'h1FF);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; op_sel = 1'b1; in_win = 9'h100;
    @(negedge clk);
    in_win = 9'h000; op_sel = 1'b0;  // offered during stall, must not be taken
    for (int k = 0; k < 3; k++) begin
      check("R7 valid held in stall", out_valid, 1'b1);
      check("R7 pix held in stall", out_pix, 1'b1);
      check("R7 in_ready low in stall", in_ready, 1'b0);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R7 drained after stall", out_valid, 1'b0);

    // Random masks and windows, R1 R2
    for (int i = 0; i < 200; i++) begin
      if (i % 10 == 0) begin
        m = C'($urandom);
        load_mask(m);
      end
      begin
        logic mo;
        logic [C-1:0] p;
        mo = 1'($urandom);
        p = C'($urandom);
        run_win(mo, p, v, got);
        check(mo ? "R2 random dilate" : "R1 random erode", got, model(mo, m, p));
      end
    end

    // R9 closing of a zero-padded frame
    m = 9'h0BA;
    load_mask(m);
    img = 25'b00000_01110_01010_01110_00000 ^ 25'h0000200;
    for (int p = 0; p < IMG * IMG; p++) begin
      run_win(1'b1, window_at(img, p / IMG, p % IMG), v, got);
      mid[p] = got;
      emid[p] = model(1'b1, m, window_at(img, p / IMG, p % IMG));
    end
    for (int p = 0; p < IMG * IMG; p++) begin
      run_win(1'b0, window_at(mid, p / IMG, p % IMG), v, got);
      fin[p] = got;
      efin[p] = model(1'b0, m, window_at(emid, p / IMG, p % IMG));
    end
    for (int p = 0; p < IMG * IMG; p++) check("R9 closing pixel", fin[p], efin[p]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule